// File: doc/BRIEF.md
# SPI Configuration Programming Sequencer

This block drives the whole command exchange that loads a configuration image into a target device through the device's SPI slave port. A host pulses `start` with the image payload length in bytes and a flag that asks for partial reconfiguration. The block then works through a fixed series of phases, and it never sends a command or a frame until the device reports that it is not busy. First it enables in-system configuration and reads back a 4-byte result, which must be zero. Next it puts the device into program mode. It then streams the payload as 16-byte frames, each taken from a valid/ready byte stream. After the last frame it disables configuration, waits a fixed delay, and releases the device.

The block does not shift bits itself. It hands one byte at a time to an SPI byte master through a request/acknowledge handshake. With each byte it passes a `hold` flag that keeps chip select asserted for the byte that follows. A status-poll submodule owns the SPI port while a poll is running. Each status read is two separate one-byte transactions, and only the reply to the second one is used. The delay timer is a second submodule.

States of the main machine, by phase:
- Start and end states: IDLE, DONE, FAIL.
- Enable phase: EN_POLL, EN_CMD, RDY_POLL, RD_CMD, RD_REPLY, RD_CHECK.
- Program mode: PM_POLL, PM_CMD.
- Frames: FR_POLL, FR_CMD, FR_DATA.
- Closing phase: DIS_POLL, DIS_CMD, WAIT, REL_POLL, REL_CMD.

Transitions:
- Start: IDLE, DONE or FAIL go to EN_POLL on `start`. They go to FAIL instead on a partial request or a bad length.
- Polls: each poll state moves to its command state when the poll succeeds, or to FAIL when it fails.
- Enable read-back: RD_CHECK goes to FAIL on a nonzero reply. Otherwise it goes to PM_POLL.
- Program mode: PM_CMD goes to FR_POLL, or to DIS_POLL when there are no frames.
- Frames: FR_DATA goes back to FR_POLL after each frame except the last, which leads to DIS_POLL.
- Closing: WAIT goes to REL_POLL when the timer expires. REL_CMD goes to DONE.

Top module: `cfgseq_sequencer`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `error`, `prog_mode`, `spi_req` and `in_ready` are all low.
- R2: Status word bits are: bit0 busy, bit1 ready, bit2 protocol violation, bit3 error. A status read is two one-byte 0x00 transactions, and only the reply to the second one is evaluated. Every command and every frame transaction comes after a poll whose evaluated status has busy clear. A request with its byte, and its hold flag, stays stable until it is acknowledged.
- R3: Configuration enable sends 0x0B alone. The block then polls until busy is clear and ready is set. It then sends 0x01 followed by four dummy bytes in one transaction. If any of the four reply bytes is nonzero, the block aborts to the error state and sends nothing more.
- R4: Program mode is entered with the transaction 0xAE, 0x01. `prog_mode` rises after this transaction is acknowledged. It stays high through the frames and the release command, and falls only when the release completes.
- R5: Each frame is one transaction: 0xEE followed by 16 payload bytes, taken in stream order. The number of frames is length/16. `in_ready` is high only in the cycle in which a payload byte is acknowledged by the SPI master.
- R6: A length that is not a multiple of 16 makes `start` set `error` on the next clock edge, and no SPI transaction is issued.
- R7: A partial reconfiguration request makes `start` set `error` on the next clock edge, and no SPI transaction is issued.
- R8: After the frames, the block sends 0x0C alone. It then waits at least WAIT_CYCLES clocks, polls, sends 0x23 alone, and enters the done state.
- R9: An evaluated status with bit2 or bit3 set aborts the sequence to the error state.
- R10: A poll that still sees busy (or not ready) after POLL_LIMIT status reads aborts to the error state. Exactly 2×POLL_LIMIT status transactions are issued.
- R11: `busy`, `done` and `error` are mutually exclusive. `done` and `error` stay set until the next accepted `start`. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming sequence (accepted when not busy) |
| partial_req | input | 1 | Request for partial reconfiguration (refused) |
| total_len | input | LEN_W | Payload length in bytes |
| in_data | input | 8 | Payload stream byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte consumed this cycle |
| spi_req | output | 1 | Byte transfer request to the SPI master |
| spi_tx | output | 8 | Byte to send |
| spi_hold | output | 1 | Keep chip select asserted after this byte |
| spi_ack | input | 1 | One-cycle acknowledge of the requested byte |
| spi_rx | input | 8 | Byte received during the acknowledged transfer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed successfully |
| error | output | 1 | Sequence refused or aborted |
| prog_mode | output | 1 | Target is in program mode |

## Verification
Most faults in the phase machine show up at the SPI port as a transaction in the wrong order or a transaction with no poll before it. The target model flags these when the transaction closes, within a few cycles of the wrong state being entered. A wrong frame counter or byte index shows up as a frame of the wrong length or with the wrong payload, or as a mismatch between the number of stream handshakes and the number of frames, once the run completes. A delay timer that expires early shows up as a short gap between the disable and release commands. A poller that evaluates the wrong reply, or counts its attempts wrongly, makes a correct run fail at the first poll, or gives the wrong number of status transactions in the timeout run.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    // Command bytes understood by the target's SPI slave port.
    localparam logic [7:0] OP_STATUS  = 8'h00;
    localparam logic [7:0] OP_READ    = 8'h01;
    localparam logic [7:0] OP_CFG_ON  = 8'h0B;
    localparam logic [7:0] OP_CFG_OFF = 8'h0C;
    localparam logic [7:0] OP_PM_A    = 8'hAE;
    localparam logic [7:0] OP_PM_B    = 8'h01;
    localparam logic [7:0] OP_FRAME   = 8'hEE;
    localparam logic [7:0] OP_RELEASE = 8'h23;

    localparam int FRAME_BYTES = 16;
    localparam int REPLY_BYTES = 4;

    // Status word bit positions.
    localparam int ST_BUSY  = 0;
    localparam int ST_READY = 1;
    localparam int ST_VIOL  = 2;
    localparam int ST_ERR   = 3;

    typedef enum logic [4:0] {
        S_IDLE, S_EN_POLL, S_EN_CMD, S_RDY_POLL, S_RD_CMD, S_RD_REPLY, S_RD_CHECK,
        S_PM_POLL, S_PM_CMD, S_FR_POLL, S_FR_CMD, S_FR_DATA,
        S_DIS_POLL, S_DIS_CMD, S_WAIT, S_REL_POLL, S_REL_CMD, S_DONE, S_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        P_IDLE, P_FIRST, P_SECOND, P_HOLD
    } poll_state_t;

endpackage

// File: rtl/cfgseq_status_poll.sv
module cfgseq_status_poll
    import cfgseq_pkg::*;
#(
    parameter int POLL_LIMIT = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       want_ready,
    output logic       spi_req,
    output logic [7:0] spi_tx,
    output logic       spi_hold,
    input  logic       spi_ack,
    input  logic [3:0] status,
    output logic       ok,
    output logic       fail
);

    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    poll_state_t      state, nxt;
    logic [CNT_W-1:0] tries;
    logic             failed_q;
    logic             bad, met, last;

    assign bad  = status[ST_VIOL] | status[ST_ERR];
    assign met  = !status[ST_BUSY] && (!want_ready || status[ST_READY]);
    assign last = (tries == CNT_W'(POLL_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= P_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            P_IDLE:   if (run) nxt = P_FIRST;
            P_FIRST:  if (spi_ack) nxt = P_SECOND;
            P_SECOND: if (spi_ack) nxt = (bad || met || last) ? P_HOLD : P_FIRST;
            P_HOLD:   if (!run) nxt = P_IDLE;
            default:  nxt = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries    <= '0;
            failed_q <= 1'b0;
        end else if (state == P_IDLE) begin
            tries    <= '0;
            failed_q <= 1'b0;
        end else if (state == P_SECOND && spi_ack) begin
            if (bad || (!met && last)) failed_q <= 1'b1;
            else if (!met)             tries    <= tries + CNT_W'(1);
        end
    end

    always_comb begin
        spi_req  = (state == P_FIRST) || (state == P_SECOND);
        spi_tx   = OP_STATUS;
        spi_hold = 1'b0;
        ok       = (state == P_HOLD) && !failed_q;
        fail     = (state == P_HOLD) && failed_q;
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tries < CNT_W'(POLL_LIMIT)) else $error("poll attempts over limit"); // R10

    AST_POLL_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && run) |=> (ok || !run)) else $error("poll result dropped early"); // R2

endmodule

// File: rtl/cfgseq_delay.sv
module cfgseq_delay #(
    parameter int WAIT_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_W'(WAIT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expired)  cnt <= cnt + CNT_W'(1);
    end

    AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WAIT_CYCLES - 1)) else $error("delay counter overrun"); // R8

endmodule

// File: rtl/cfgseq_sequencer.sv
module cfgseq_sequencer
    import cfgseq_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int POLL_LIMIT  = 100000,
    parameter int WAIT_CYCLES = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             partial_req,
    input  logic [LEN_W-1:0] total_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             spi_req,
    output logic [7:0]       spi_tx,
    output logic             spi_hold,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rx,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic             prog_mode
);

    localparam int FRM_W  = LEN_W - 4;
    localparam int GAP_W  = $clog2(WAIT_CYCLES + 2);
    localparam logic [3:0] LAST_DATA  = 4'(FRAME_BYTES - 1);
    localparam logic [3:0] LAST_REPLY = 4'(REPLY_BYTES - 1);

    seq_state_t       state, nxt;
    logic [FRM_W-1:0] nframes, frame_idx;
    logic [3:0]       bcnt;
    logic             reply_nz, pm_q;
    logic             idle_like, launch, len_bad, last_frame;
    logic             poll_run, want_ready, p_req, p_hold, p_ok, p_fail;
    logic [7:0]       p_tx;
    logic             wait_run, wait_done;

    assign idle_like  = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);
    assign launch     = start && idle_like;
    assign len_bad    = |total_len[3:0];
    assign last_frame = ((frame_idx + FRM_W'(1)) == nframes);
    assign poll_run   = state inside {S_EN_POLL, S_RDY_POLL, S_PM_POLL,
                                      S_FR_POLL, S_DIS_POLL, S_REL_POLL};
    assign want_ready = (state == S_RDY_POLL);
    assign wait_run   = (state == S_WAIT);
    assign prog_mode  = pm_q;

    cfgseq_status_poll #(.POLL_LIMIT(POLL_LIMIT)) i_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (poll_run),
        .want_ready (want_ready),
        .spi_req    (p_req),
        .spi_tx     (p_tx),
        .spi_hold   (p_hold),
        .spi_ack    (spi_ack),
        .status     (spi_rx[3:0]),
        .ok         (p_ok),
        .fail       (p_fail)
    );

    cfgseq_delay #(.WAIT_CYCLES(WAIT_CYCLES)) i_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (wait_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    if (partial_req || len_bad) nxt = S_FAIL;
                    else                        nxt = S_EN_POLL;
                end
            end
            S_EN_POLL:  if (p_fail) nxt = S_FAIL; else if (p_ok) nxt = S_EN_CMD;
            S_EN_CMD:   if (spi_ack) nxt = S_RDY_POLL;
            S_RDY_POLL: if (p_fail) nxt = S_FAIL; else if (p_ok) nxt = S_RD_CMD;
            S_RD_CMD:   if (spi_ack) nxt = S_RD_REPLY;
            S_RD_REPLY: if (spi_ack && bcnt == LAST_REPLY) nxt = S_RD_CHECK;
            S_RD_CHECK: nxt = reply_nz ? S_FAIL : S_PM_POLL;
            S_PM_POLL:  if (p_fail) nxt = S_FAIL; else if (p_ok) nxt = S_PM_CMD;
            S_PM_CMD: begin
                if (spi_ack && bcnt == 4'd1)
                    nxt = (nframes == '0) ? S_DIS_POLL : S_FR_POLL;
            end
            S_FR_POLL:  if (p_fail) nxt = S_FAIL; else if (p_ok) nxt = S_FR_CMD;
            S_FR_CMD:   if (spi_ack) nxt = S_FR_DATA;
            S_FR_DATA: begin
                if (spi_ack && bcnt == LAST_DATA)
                    nxt = last_frame ? S_DIS_POLL : S_FR_POLL;
            end
            S_DIS_POLL: if (p_fail) nxt = S_FAIL; else if (p_ok) nxt = S_DIS_CMD;
            S_DIS_CMD:  if (spi_ack) nxt = S_WAIT;
            S_WAIT:     if (wait_done) nxt = S_REL_POLL;
            S_REL_POLL: if (p_fail) nxt = S_FAIL; else if (p_ok) nxt = S_REL_CMD;
            S_REL_CMD:  if (spi_ack) nxt = S_DONE;
            default:    nxt = S_IDLE;
        endcase
    end

    // Counters and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nframes   <= '0;
            frame_idx <= '0;
            bcnt      <= '0;
            reply_nz  <= 1'b0;
            pm_q      <= 1'b0;
        end else begin
            if (launch) begin
                nframes   <= total_len[LEN_W-1:4];
                frame_idx <= '0;
            end else if (state == S_FR_DATA && spi_ack && bcnt == LAST_DATA) begin
                frame_idx <= frame_idx + FRM_W'(1);
            end
            if (nxt != state)  bcnt <= '0;
            else if (spi_ack)  bcnt <= bcnt + 4'd1;
            if (state == S_RD_CMD)                   reply_nz <= 1'b0;
            else if (state == S_RD_REPLY && spi_ack) reply_nz <= reply_nz | (|spi_rx);
            if (state == S_PM_CMD && spi_ack && bcnt == 4'd1) pm_q <= 1'b1;
            else if (state == S_REL_CMD && spi_ack)           pm_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        spi_req  = 1'b0;
        spi_tx   = OP_STATUS;
        spi_hold = 1'b0;
        in_ready = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        error    = 1'b0;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_DONE: begin busy = 1'b0; done = 1'b1; end
            S_FAIL: begin busy = 1'b0; error = 1'b1; end
            S_EN_POLL, S_RDY_POLL, S_PM_POLL, S_FR_POLL, S_DIS_POLL, S_REL_POLL: begin
                spi_req  = p_req;
                spi_tx   = p_tx;
                spi_hold = p_hold;
            end
            S_EN_CMD: begin spi_req = 1'b1; spi_tx = OP_CFG_ON; end
            S_RD_CMD: begin spi_req = 1'b1; spi_tx = OP_READ; spi_hold = 1'b1; end
            S_RD_REPLY: begin
                spi_req  = 1'b1;
                spi_hold = (bcnt != LAST_REPLY);
            end
            S_RD_CHECK: ;
            S_PM_CMD: begin
                spi_req  = 1'b1;
                spi_tx   = (bcnt == 4'd0) ? OP_PM_A : OP_PM_B;
                spi_hold = (bcnt == 4'd0);
            end
            S_FR_CMD: begin spi_req = 1'b1; spi_tx = OP_FRAME; spi_hold = 1'b1; end
            S_FR_DATA: begin
                spi_req  = in_valid;
                spi_tx   = in_data;
                spi_hold = (bcnt != LAST_DATA);
                in_ready = spi_ack;
            end
            S_DIS_CMD: begin spi_req = 1'b1; spi_tx = OP_CFG_OFF; end
            S_WAIT: ;
            S_REL_CMD: begin spi_req = 1'b1; spi_tx = OP_RELEASE; end
            default: busy = 1'b0;
        endcase
    end

    // Checker-side gap counter: cycles since the disable command was last on the port
    logic [GAP_W-1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || state == S_DIS_CMD)            gap_cnt <= '0;
        else if (gap_cnt != GAP_W'(WAIT_CYCLES + 1)) gap_cnt <= gap_cnt + GAP_W'(1);
    end

    AST_WAIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REL_CMD) |-> (gap_cnt >= GAP_W'(WAIT_CYCLES))) else $error("release too early"); // R8

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx) && $stable(spi_hold))) else $error("request changed before ack"); // R2

    AST_STREAM_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (spi_req && spi_tx == in_data && pm_q)) else $error("stream consumed outside frame"); // R5

    AST_BADLEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle_like && len_bad) |=> error) else $error("bad length accepted"); // R6

    AST_PARTIAL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle_like && partial_req) |=> error) else $error("partial request accepted"); // R7

    AST_PM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_mode) |-> done) else $error("program mode left without completion"); // R4

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, error})) else $error("status flags overlap"); // R11

endmodule

// File: tb/test_cfgseq_sequencer.sv
module test_cfgseq_sequencer;

    localparam int LEN_W = 8;
    localparam int PL    = 6;
    localparam int WC    = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             partial_req = 1'b0;
    logic [LEN_W-1:0] total_len = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             spi_req;
    logic [7:0]       spi_tx;
    logic             spi_hold;
    logic             spi_ack = 1'b0;
    logic [7:0]       spi_rx = '0;
    logic             busy, done, error, prog_mode;

    cfgseq_sequencer #(.LEN_W(LEN_W), .POLL_LIMIT(PL), .WAIT_CYCLES(WC)) i_cfgseq_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .partial_req(partial_req),
        .total_len(total_len), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_hold(spi_hold), .spi_ack(spi_ack),
        .spi_rx(spi_rx), .busy(busy), .done(done), .error(error), .prog_mode(prog_mode)
    );

    // 50 MHz: 20 time units per period
    initial forever #10 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 0;

    // target model configuration
    int busy_n = 0; bit stuck = 0, inj_err = 0, inj_viol = 0, stall = 0;
    logic [31:0] reply_val = '0;
    // target model observations
    int busy_left, stat_cnt, viol, cmd_cnt, en_cnt, rd_cnt, pm_cnt, fr_cnt, dis_cnt, rel_cnt;
    int data_err, order_err, pm_err, stage, dis_cyc, gap, pos, consumed, hs_cnt;
    bit polled_ok;
    logic [7:0] tb_buf [0:17];

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_ge(string req, string what, int act, int lim);
        n_chk++;
        if (act < lim) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected>=%0d", req, what, act, lim);
        end
    endtask

    task automatic close_txn(int len);
        if (len == 1 && tb_buf[0] == 8'h00) begin
            stat_cnt++;
            if (stat_cnt % 2 == 0) begin
                if (stuck || busy_left > 0) begin
                    if (busy_left > 0) busy_left--;
                end else polled_ok = 1;
            end
        end else begin
            cmd_cnt++;
            if (!polled_ok) viol++;
            polled_ok = 0;
            busy_left = busy_n;
            if (len == 1 && tb_buf[0] == 8'h0B) begin
                if (stage != 0) order_err++;
                stage = 1; en_cnt++;
            end else if (len == 5 && tb_buf[0] == 8'h01) begin
                if (stage != 1) order_err++;
                stage = 2; rd_cnt++;
            end else if (len == 2 && tb_buf[0] == 8'hAE && tb_buf[1] == 8'h01) begin
                if (stage != 2) order_err++;
                stage = 3; pm_cnt++;
            end else if (len == 17 && tb_buf[0] == 8'hEE) begin
                if (stage != 3) order_err++;
                for (int i = 1; i <= 16; i++)
                    if (tb_buf[i] != pat(fr_cnt * 16 + i - 1)) data_err++;
                if (!prog_mode) pm_err++;
                fr_cnt++;
            end else if (len == 1 && tb_buf[0] == 8'h0C) begin
                if (stage != 3) order_err++;
                stage = 4; dis_cnt++; dis_cyc = cyc;
            end else if (len == 1 && tb_buf[0] == 8'h23) begin
                if (stage != 4) order_err++;
                stage = 5; rel_cnt++; gap = cyc - dis_cyc;
                if (!prog_mode) pm_err++;
            end else order_err++;
        end
    endtask

    // Target device model and payload stream source
    initial begin
        bit hs;
        forever begin
            @(negedge clk);
            cyc++;
            if (spi_ack) spi_ack = 1'b0;
            else if (spi_req) begin
                if (pos == 0) begin
                    if (stat_cnt % 2 == 0) spi_rx = 8'h0C;
                    else spi_rx = {4'b0, inj_err, inj_viol, 1'b1, (stuck || busy_left > 0)};
                end else if (tb_buf[0] == 8'h01 && pos <= 4) spi_rx = reply_val[8*(pos-1) +: 8];
                else spi_rx = 8'h00;
                if (pos < 18) tb_buf[pos] = spi_tx;
                pos++;
                if (!spi_hold) begin
                    close_txn(pos);
                    pos = 0;
                end
                spi_ack = 1'b1;
            end
            #1 hs = in_valid && in_ready;
            @(posedge clk);
            #1;
            if (hs) begin
                consumed++; hs_cnt++;
                in_data  = pat(consumed);
                in_valid = !stall;
            end else in_valid = 1'b1;
        end
    end

    task automatic clear_model();
        busy_left = 0; stat_cnt = 0; viol = 0; cmd_cnt = 0; en_cnt = 0; rd_cnt = 0;
        pm_cnt = 0; fr_cnt = 0; dis_cnt = 0; rel_cnt = 0; data_err = 0; order_err = 0;
        pm_err = 0; stage = 0; dis_cyc = 0; gap = 0; pos = 0; consumed = 0; hs_cnt = 0;
        polled_ok = 0;
    endtask

    task automatic run_seq(int len, bit part, bit poke);
        clear_model();
        in_data = pat(0);
        @(negedge clk); #2;
        total_len = LEN_W'(len); partial_req = part; start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0; partial_req = 1'b0;
        for (int t = 0; t < 20000 && !(done || error); t++) begin
            @(negedge clk); #2;
            if (poke && t == 10) begin
                start = 1'b1; partial_req = 1'b1; total_len = 8'd3;
            end else start = 1'b0;
        end
        start = 1'b0; partial_req = 1'b0;
        repeat (3) @(negedge clk);
        #2;
    endtask

    task automatic good_run(int nfr, int bn, bit stl, bit poke);
        busy_n = bn; stall = stl; stuck = 0; inj_err = 0; inj_viol = 0; reply_val = '0;
        run_seq(nfr * 16, 1'b0, poke);
        check("R11", "done", done, 1);
        check("R11", "error", error, 0);
        check("R11", "busy", busy, 0);
        check("R2", "unpolled commands", viol, 0);
        check("R3", "enable commands", en_cnt, 1);
        check("R3", "read-back commands", rd_cnt, 1);
        check("R4", "program-mode commands", pm_cnt, 1);
        check("R4", "prog_mode low at frame/release", pm_err, 0);
        check("R4", "prog_mode after release", prog_mode, 0);
        check("R5", "frames", fr_cnt, nfr);
        check("R5", "payload mismatches", data_err, 0);
        check("R5", "stream handshakes", hs_cnt, nfr * 16);
        check("R8", "command order", order_err, 0);
        check("R8", "release commands", rel_cnt, 1);
        check_ge("R8", "disable-release gap", gap, WC);
        repeat (5) @(negedge clk);
        check("R11", "done sticky", done, 1);
    endtask

    task automatic refused_run(int len, bit part, string req);
        busy_n = 0; stall = 0; stuck = 0; inj_err = 0; inj_viol = 0; reply_val = '0;
        clear_model();
        @(negedge clk); #2;
        total_len = LEN_W'(len); partial_req = part; start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0; partial_req = 1'b0;
        check(req, "error one edge after start", error, 1);
        check(req, "busy", busy, 0);
        repeat (6) @(negedge clk);
        check(req, "transactions issued", cmd_cnt + stat_cnt, 0);
        check(req, "error sticky", error, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "error", error, 0);
        check("R1", "prog_mode", prog_mode, 0);
        check("R1", "spi_req", spi_req, 0);
        check("R1", "in_ready", in_ready, 0);
        #2 rst_n = 1'b1;

        for (int nfr = 0; nfr <= 4; nfr++)
            for (int bn = 0; bn <= 2; bn++)
                good_run(nfr, bn, 1'b0, 1'b0);
        good_run(3, 1, 1'b1, 1'b0);
        good_run(2, 0, 1'b0, 1'b1);

        for (int len = 1; len < 48; len += 5)
            if (len % 16 != 0) refused_run(len, 1'b0, "R6");
        refused_run(32, 1'b1, "R7");
        good_run(1, 0, 1'b0, 1'b0);

        for (int k = 0; k < 4; k++) begin
            busy_n = 0; stall = 0; stuck = 0; inj_err = 0; inj_viol = 0;
            reply_val = 32'h1 << (8 * k + 3);
            run_seq(32, 1'b0, 1'b0);
            check("R3", "error on nonzero reply", error, 1);
            check("R3", "read-back issued", rd_cnt, 1);
            check("R3", "no program mode", pm_cnt + fr_cnt, 0);
            check("R3", "prog_mode", prog_mode, 0);
        end

        for (int m = 0; m < 2; m++) begin
            busy_n = 0; stall = 0; stuck = 0; reply_val = '0;
            inj_err = (m == 0); inj_viol = (m == 1);
            run_seq(16, 1'b0, 1'b0);
            check("R9", "error on status fault", error, 1);
            check("R9", "no command issued", cmd_cnt, 0);
            check("R9", "one status read", stat_cnt, 2);
        end
        inj_err = 0; inj_viol = 0;

        busy_n = 0; stuck = 1; reply_val = '0;
        run_seq(16, 1'b0, 1'b0);
        check("R10", "error on timeout", error, 1);
        check("R10", "status transactions", stat_cnt, 2 * PL);
        check("R10", "no command issued", cmd_cnt, 0);
        stuck = 0;

        good_run(4, 2, 1'b1, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule